// File: doc/BRIEF.md
# Multi-format serial audio receiver

The receiver takes a stereo PCM stream carried on three wires: a bit clock, a word (channel) clock and a serial data line. It turns that stream into signed 24-bit left and right samples and raises a one-cycle strobe each time a new stereo pair is ready. A static format input selects one of four framings: MSB-first right-justified, MSB-first left-justified, LSB-first right-justified and I2S. For MSB-first right-justified data, a second static input selects a word length of 16, 20 or 24 bits. Words shorter than 24 bits are sign-extended.

All logic runs on a system clock that is much faster than the bit clock. Each of the three serial inputs passes through a two-flop synchroniser, and a bit is taken on each detected rising edge of the bit clock. Every level change of the word clock marks a word boundary. The block locks onto the stream from these boundaries alone, so after reset, or after a disturbance, it realigns at the next word-clock transition. It is meant for stream sample rates from 32 kHz to 192 kHz, and so for bit clocks well below a quarter of the system clock.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, `left_out` and `right_out` are zero and `sample_valid` is low until the first complete stereo pair has been received.
- R2: With `fmt_sel` = 0 (MSB-first right-justified) and `rj_len` = 2 or 3 (24 bits), a sample is the last 24 bits received before the word clock changes level. The first of those 24 bits is the MSB and the last is the LSB.
- R3: With `fmt_sel` = 0, `rj_len` = 0 selects 16 bits and `rj_len` = 1 selects 20 bits. The sample is the last 16 or 20 bits before the word-clock change, sign-extended to 24 bits.
- R4: With `fmt_sel` = 2 (LSB-first right-justified), a sample is the last 24 bits before the word-clock change. The earliest of those bits is the LSB and the last is the MSB. `rj_len` has no effect in this mode.
- R5: With `fmt_sel` = 1 (MSB-first left-justified), the bit taken on the first rising bit-clock edge that sees the new word-clock level is the MSB, followed by 23 more bits. In a slot shorter than 24 bits, the missing low bits are zero.
- R6: With `fmt_sel` = 3 (I2S), the MSB is the bit taken one bit clock after the first edge that sees the new word-clock level, followed by 23 more bits. This mode needs slots of at least 25 bit clocks.
- R7: Word clock low marks the left channel and high marks the right channel. A left word followed by a right word forms a pair. The pair appears on `left_out` and `right_out` together, with `sample_valid` high, once the right word has ended at the next word-clock fall.
- R8: Bits in a slot that lie outside the active word have no effect on the sample. In right-justified modes these are the leading bits; in left-justified and I2S modes they are the trailing bits.
- R9: A word that was already in progress when reset was released is discarded. No pair is output until a left word and the right word after it have both started at observed word-clock transitions.
- R10: `sample_valid` is high for exactly one system-clock cycle per pair. `left_out` and `right_out` change only in a cycle in which `sample_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Framing: 0 MSB-first RJ, 1 MSB-first LJ, 2 LSB-first RJ, 3 I2S |
| rj_len | input | 2 | Word length for MSB-first RJ: 0 = 16, 1 = 20, 2 or 3 = 24 |
| sck_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Word clock: low = left, high = right, asynchronous |
| sd_in | input | 1 | Serial data, asynchronous |
| left_out | output | 24 | Signed left sample |
| right_out | output | 24 | Signed right sample |
| sample_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The hardest case to reach from the ports is the start-up boundary. Here reset is released partway through a left word, and the receiver must discard both that fragment and the right word that follows it, rather than pairing the fragment with valid data. The bench reaches this case by resetting and then sending a deliberately shortened left slot before the full frames. It then checks that exactly one pair, the later one, comes out.

The slots in the bench are longer than the word and are filled with ones outside the word. As a result, a wrong choice of which bits belong to the word shows up as a wrong sample value rather than passing unnoticed.

// File: rtl/sarx_pkg.sv
// Shared constants and encodings for the serial audio receiver.
// Assumes: the output sample width is fixed at 24 bits; the two short
// right-justified lengths are 16 and 20 bits.
package sarx_pkg;
    localparam int SAMPLE_W = 24;
    localparam int SHORT_A  = 16;
    localparam int SHORT_B  = 20;

    typedef enum logic [1:0] {
        FMT_RJ_MSB = 2'd0,
        FMT_LJ_MSB = 2'd1,
        FMT_RJ_LSB = 2'd2,
        FMT_I2S    = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        LEN_16  = 2'd0,
        LEN_20  = 2'd1,
        LEN_24  = 2'd2,
        LEN_24X = 2'd3
    } rjlen_e;

    // Sign-extend the low n bits of v to the full sample width.
    function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] v, input int n);
        logic [SAMPLE_W-1:0] r;
        for (int k = 0; k < SAMPLE_W; k++) begin
            r[k] = (k < n) ? v[k] : v[n-1];
        end
        return r;
    endfunction
endpackage

// File: rtl/sarx_sync.sv
// Multi-bit synchroniser: each input bit goes through its own chain of
// STAGES flops into the clk domain.
// Assumes: the bits are independent levels, and bits that must line up
// change well apart from the edges that qualify them.
module sarx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift each input bit through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sarx_framer.sv
// Framer: detects rising edges of the bit clock and word-clock level
// changes, and numbers each bit within its word.
// Assumes: synchronised inputs; the bit clock is high and low for at least
// one clk cycle each.
module sarx_framer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_s,
    input  logic             ws_s,
    output logic             bit_ev,
    output logic             chg,
    output logic             word_end,
    output logic             end_ch,
    output logic [CNT_W-1:0] bit_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             sck_d;
    logic             ws_last;
    logic             primed;
    logic             armed;
    logic [CNT_W-1:0] cnt_q;

    assign bit_ev   = sck_s & ~sck_d;
    assign chg      = bit_ev & primed & (ws_s != ws_last);
    assign word_end = chg & armed;
    assign end_ch   = ws_last;
    assign bit_idx  = chg ? '0 : cnt_q;

    // Delay the bit clock by one cycle for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Track the word-clock level, alignment state and bit position per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_last <= 1'b0;
            primed  <= 1'b0;
            armed   <= 1'b0;
            cnt_q   <= '0;
        end else if (bit_ev) begin
            ws_last <= ws_s;
            primed  <= 1'b1;
            if (chg) armed <= 1'b1;
            cnt_q   <= (bit_idx == CNT_MAX) ? CNT_MAX : bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/sarx_deser.sv
// Deserialiser: collects bits into a 24-bit word according to the selected
// framing, and presents the completed word when a word ends.
// Assumes: fmt and rjl are static while a stream is running.
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_e                fmt,
    input  rjlen_e              rjl,
    input  logic                bit_ev,
    input  logic                chg,
    input  logic [CNT_W-1:0]    bit_idx,
    input  logic                sd,
    output logic [SAMPLE_W-1:0] word_val
);
    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] jw_q;
    logic [SAMPLE_W-1:0] jw_next;
    int                  rel;

    // Compute the next left-justified word: clear at a boundary, then place
    // this bit at its position counted from the MSB.
    always_comb begin
        rel     = int'(bit_idx) - ((fmt == FMT_I2S) ? 1 : 0);
        jw_next = chg ? '0 : jw_q;
        for (int k = 0; k < SAMPLE_W; k++) begin
            if (rel == SAMPLE_W - 1 - k) jw_next[k] = sd;
        end
    end

    // Keep a window of the most recent bits for right-justified framings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (bit_ev) begin
            if (fmt == FMT_RJ_LSB) sh_q <= {sd, sh_q[SAMPLE_W-1:1]};
            else                   sh_q <= {sh_q[SAMPLE_W-2:0], sd};
        end
    end

    // Hold the word being built for left-justified and I2S framings.
    always_ff @(posedge clk) begin
        if (!rst_n)      jw_q <= '0;
        else if (bit_ev) jw_q <= jw_next;
    end

    // Select the completed word for the active framing and length.
    always_comb begin
        unique case (fmt)
            FMT_RJ_MSB: begin
                unique case (rjl)
                    LEN_16:  word_val = sext(sh_q, SHORT_A);
                    LEN_20:  word_val = sext(sh_q, SHORT_B);
                    default: word_val = sh_q;
                endcase
            end
            FMT_RJ_LSB: word_val = sh_q;
            default:    word_val = jw_q;
        endcase
    end
endmodule

// File: rtl/sarx_pair.sv
// Pairing stage: holds a left word until the matching right word ends,
// then updates both outputs together with a one-cycle strobe.
// Assumes: word_end lasts one cycle and end_ch names the channel that ended.
module sarx_pair
    import sarx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_end,
    input  logic                end_ch,
    input  logic [SAMPLE_W-1:0] word_val,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    logic [SAMPLE_W-1:0] left_hold;
    logic                have_left;

    // Store left words; publish a pair when a right word ends after one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold    <= '0;
            have_left    <= 1'b0;
            left_out     <= '0;
            right_out    <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (word_end) begin
                if (!end_ch) begin
                    left_hold <= word_val;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_out     <= left_hold;
                    right_out    <= word_val;
                    sample_valid <= 1'b1;
                    have_left    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
// Top level of the multi-format serial audio receiver: synchroniser,
// framer, deserialiser and pairing stage.
// Assumes: the bit clock is slower than a quarter of clk; fmt_sel and
// rj_len change only while no stream is running.
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          rj_len,
    input  logic                sck_in,
    input  logic                ws_in,
    input  logic                sd_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid
);
    logic [2:0]          sync_out;
    logic                sck_s, ws_s, sd_s;
    logic                bit_ev, chg, word_end, end_ch;
    logic [CNT_W-1:0]    bit_idx;
    logic [SAMPLE_W-1:0] word_val;

    sarx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_in, ws_in, sd_in}),
        .dout (sync_out)
    );

    assign {sck_s, ws_s, sd_s} = sync_out;

    sarx_framer #(.CNT_W(CNT_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .ws_s    (ws_s),
        .bit_ev  (bit_ev),
        .chg     (chg),
        .word_end(word_end),
        .end_ch  (end_ch),
        .bit_idx (bit_idx)
    );

    sarx_deser #(.CNT_W(CNT_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt_e'(fmt_sel)),
        .rjl     (rjlen_e'(rj_len)),
        .bit_ev  (bit_ev),
        .chg     (chg),
        .bit_idx (bit_idx),
        .sd      (sd_s),
        .word_val(word_val)
    );

    sarx_pair u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_end    (word_end),
        .end_ch      (end_ch),
        .word_val    (word_val),
        .left_out    (left_out),
        .right_out   (right_out),
        .sample_valid(sample_valid)
    );
endmodule

// File: rtl/sarx_checker.sv
// Assertion checker for serial_audio_rx, attached with bind.
module sarx_checker
    import sarx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          fmt_sel,
    input logic [1:0]          rj_len,
    input logic                bit_ev,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                sample_valid
);
    // R10: the strobe never lasts two cycles.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R10: outputs change only together with the strobe.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_out) && $stable(right_out)));

    // R7: a pair is published only in response to a bit-clock edge.
    a_r7_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(bit_ev));

    // R3: 16-bit right-justified samples are sign-extended.
    a_r3_sext16: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && fmt_sel == 2'd0 && rj_len == 2'd0) |->
        (($countones(left_out[23:15]) == 0 || $countones(left_out[23:15]) == 9) &&
         ($countones(right_out[23:15]) == 0 || $countones(right_out[23:15]) == 9)));

    // R3: 20-bit right-justified samples are sign-extended.
    a_r3_sext20: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && fmt_sel == 2'd0 && rj_len == 2'd1) |->
        (($countones(left_out[23:19]) == 0 || $countones(left_out[23:19]) == 5) &&
         ($countones(right_out[23:19]) == 0 || $countones(right_out[23:19]) == 5)));
endmodule

bind serial_audio_rx sarx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_sel     (fmt_sel),
    .rj_len      (rj_len),
    .bit_ev      (bit_ev),
    .left_out    (left_out),
    .right_out   (right_out),
    .sample_valid(sample_valid)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
    localparam int HB = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  rjl = 2'd2;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [23:0] l_o, r_o;
    logic        vld;

    int checks = 0, errors = 0;
    logic [23:0] cap_l [$];
    logic [23:0] cap_r [$];
    int run = 0, max_run = 0, hold_err = 0;
    logic [23:0] pl = '0, pr = '0;

    always #2 clk = ~clk;

    serial_audio_rx dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt), .rj_len(rjl),
        .sck_in(sck), .ws_in(ws), .sd_in(sd),
        .left_out(l_o), .right_out(r_o), .sample_valid(vld)
    );

    // Monitor: capture pairs, measure strobe width, watch output stability.
    always @(negedge clk) begin
        if (rst_n) begin
            if (vld) begin
                cap_l.push_back(l_o);
                cap_r.push_back(r_o);
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
                if (l_o !== pl || r_o !== pr) hold_err++;
            end
        end
        pl = l_o;
        pr = r_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0;
        tick(5);
        cap_l.delete(); cap_r.delete();
        rst_n = 1'b1;
        tick(3);
    endtask

    task automatic send_bit(input logic w, input logic b);
        sck = 1'b0; ws = w; sd = b;
        tick(HB);
        sck = 1'b1;
        tick(HB);
    endtask

    function automatic logic slot_bit(input int i, input int s, input logic [23:0] v,
                                      input logic pad);
        int n;
        n = (fmt == 2'd0 && rjl == 2'd0) ? 16 : (fmt == 2'd0 && rjl == 2'd1) ? 20 : 24;
        case (fmt)
            2'd0:    return (i >= s - n) ? v[n-1-(i-(s-n))] : pad;
            2'd2:    return (i >= s - 24) ? v[i-(s-24)] : pad;
            2'd1:    return (i < 24) ? v[23-i] : pad;
            default: return (i >= 1 && i <= 24) ? v[24-i] : pad;
        endcase
    endfunction

    function automatic logic [23:0] expect_val(input logic [23:0] v);
        if (fmt == 2'd0 && rjl == 2'd0) return {{8{v[15]}}, v[15:0]};
        if (fmt == 2'd0 && rjl == 2'd1) return {{4{v[19]}}, v[19:0]};
        return v;
    endfunction

    task automatic send_slot(input logic w, input logic [23:0] v, input int s, input logic pad);
        for (int i = 0; i < s; i++) send_bit(w, slot_bit(i, s, v, pad));
    endtask

    // Two full frames after a short right-channel preamble; expect two pairs.
    task automatic do_frames(input string req, input logic [1:0] f, input logic [1:0] len,
                             input int s, input logic pad,
                             input logic [23:0] l0, input logic [23:0] r0,
                             input logic [23:0] l1, input logic [23:0] r1);
        fmt = f; rjl = len;
        reset_dut();
        send_slot(1'b1, 24'h0, 6, pad);
        send_slot(1'b0, l0, s, pad);
        send_slot(1'b1, r0, s, pad);
        send_slot(1'b0, l1, s, pad);
        send_slot(1'b1, r1, s, pad);
        send_bit(1'b0, pad);
        send_bit(1'b0, pad);
        tick(20);
        check(cap_l.size() == 2, req, "pair count", 24'(cap_l.size()), 24'd2);
        if (cap_l.size() == 2) begin
            check(cap_l[0] == expect_val(l0), req, "left 0", cap_l[0], expect_val(l0));
            check(cap_r[0] == expect_val(r0), req, "right 0", cap_r[0], expect_val(r0));
            check(cap_l[1] == expect_val(l1), req, "left 1", cap_l[1], expect_val(l1));
            check(cap_r[1] == expect_val(r1), req, "right 1", cap_r[1], expect_val(r1));
        end
    endtask

    task automatic t_reset();
        reset_dut();
        check(l_o == 24'h0, "R1", "left after reset", l_o, 24'h0);
        check(r_o == 24'h0, "R1", "right after reset", r_o, 24'h0);
        check(vld == 1'b0, "R1", "valid after reset", 24'(vld), 24'h0);
    endtask

    task automatic t_rj24();
        do_frames("R2/R8", 2'd0, 2'd2, 32, 1'b1, 24'h123456, 24'h800001, 24'h7FFFFE, 24'hA5C30F);
    endtask

    task automatic t_rj16();
        do_frames("R3 16-bit", 2'd0, 2'd0, 32, 1'b1, 24'h00_8001, 24'h00_7FFF, 24'h00_1234, 24'h00_F00D);
    endtask

    task automatic t_rj20();
        do_frames("R3 20-bit", 2'd0, 2'd1, 24, 1'b1, 24'h0_80005, 24'h0_7FFFF, 24'h0_ABCDE, 24'h0_01234);
    endtask

    task automatic t_rj_lsb();
        do_frames("R4", 2'd2, 2'd0, 32, 1'b1, 24'h123456, 24'hFEDCBA, 24'h000001, 24'h800000);
    endtask

    task automatic t_lj();
        do_frames("R5/R8", 2'd1, 2'd0, 32, 1'b1, 24'hC0FFEE, 24'h0F0F0F, 24'h800000, 24'h000001);
    endtask

    task automatic t_lj_short();
        fmt = 2'd1; rjl = 2'd2;
        reset_dut();
        send_slot(1'b1, 24'h0, 4, 1'b0);
        send_slot(1'b0, 24'hABCDEF, 16, 1'b0);
        send_slot(1'b1, 24'h135799, 16, 1'b0);
        send_bit(1'b0, 1'b0);
        tick(20);
        check(cap_l.size() == 1, "R5 short slot", "pair count", 24'(cap_l.size()), 24'd1);
        if (cap_l.size() == 1) begin
            check(cap_l[0] == 24'hABCD00, "R5 short slot", "left", cap_l[0], 24'hABCD00);
            check(cap_r[0] == 24'h135700, "R5 short slot", "right", cap_r[0], 24'h135700);
        end
    endtask

    task automatic t_i2s();
        do_frames("R6", 2'd3, 2'd2, 32, 1'b1, 24'h876543, 24'h00FF00, 24'h7FFFFF, 24'h800001);
    endtask

    task automatic t_startup();
        fmt = 2'd1; rjl = 2'd2;
        reset_dut();
        send_slot(1'b0, 24'hDEAD00, 10, 1'b1);
        send_slot(1'b1, 24'h111111, 32, 1'b1);
        send_slot(1'b0, 24'h222222, 32, 1'b1);
        send_slot(1'b1, 24'h333333, 32, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        tick(20);
        check(cap_l.size() == 1, "R9", "pair count", 24'(cap_l.size()), 24'd1);
        if (cap_l.size() == 1) begin
            check(cap_l[0] == 24'h222222, "R9", "left", cap_l[0], 24'h222222);
            check(cap_r[0] == 24'h333333, "R9", "right", cap_r[0], 24'h333333);
        end
    endtask

    task automatic t_strobe();
        check(max_run == 1, "R10", "strobe width", 24'(max_run), 24'd1);
        check(hold_err == 0, "R10", "output changes without strobe", 24'(hold_err), 24'd0);
        check(max_run > 0, "R7", "pairs were published", 24'(max_run), 24'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rj24();
        t_rj16();
        t_rj20();
        t_rj_lsb();
        t_lj();
        t_lj_short();
        t_i2s();
        t_startup();
        t_strobe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule